// File: doc/BRIEF.md
# DMA Channel Pause/Stop Controller

This block keeps the control state of a single DMA channel and decides, cycle by cycle, what the channel does with software commands and with events from the data engine. It tracks three pieces of state: a status (idle, paused or busy), a pending request (none, stop or pause) and a configured flag. It also keeps a count of the chunks that have not yet been started.

Software sends one-cycle command pulses: configure, issue, pause, resume and terminate. The data engine reports a done pulse when a chunk finishes and an abort pulse when it gives up. The engine also drives a level that says it has no work in flight. The block answers each served command with a one-cycle accept or reject. It sends a start pulse to launch the next chunk and a complete pulse when the channel's work ends.

Pause and stop do not interrupt a running chunk. They are recorded as pending requests and take effect at the next done event. Terminate can also recover a channel that looks busy while the engine already reports that it has finished.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous active-low reset the status is idle, no request is pending, the channel is unconfigured, and ack, nak, start and complete are all low.
- R2: Status is reported as idle=0, paused=1, busy=2. The pending request is reported as none=0, stop=1, pause=2.
- R3: Each served command produces exactly one of ack or nak, for one cycle, in the cycle after the pulse. All state and pulse outputs are registered and update on that same edge. When several commands arrive together, only one is served, in the order terminate, pause, resume, issue, configure. The others get no response and have no effect.
- R4: Configure always gets an ack and sets the configured flag.
- R5: Issue gets an ack only when the channel is configured, no request is pending, the status is idle and chunk_cnt_i is non-zero. On success the status becomes busy, start pulses, and chunk_cnt_i chunks are launched in total, one per start. Otherwise it gets a nak with no state change.
- R6: Pause gets an ack only when the channel is configured, busy and has no pending request. The request then becomes pause. Otherwise it gets a nak.
- R7: Resume gets an ack only when the channel is configured, paused and has no pending request. The status then becomes busy and start pulses. Otherwise it gets a nak.
- R8: A done event while busy with no pending request pulses start if chunks remain. If none remain, it pulses complete and the status becomes idle.
- R9: A done event while busy with a pending stop pulses complete, clears the request and sets the status to idle. With a pending pause, it clears the request and sets the status to paused without pulsing start or complete.
- R10: An abort event while busy pulses complete, clears the request and sets the status to idle. If abort and done arrive together, abort wins.
- R11: Terminate gets an ack and changes nothing when unconfigured. When idle or paused, it gets an ack, clears the configured flag and leaves the status idle.
- R12: Terminate while busy with eng_idle_i high gets an ack, sets the status to idle, clears the request and clears the configured flag. Otherwise, with a stop already pending it gets a nak. In every other case it gets an ack and records a stop request.
- R13: A command pulse in the same cycle as a done or abort input gets a nak and has no effect. Done and abort are ignored unless the status is busy.
- R14: The remaining-chunk count saturates at zero. A resume after the last chunk has been launched still pulses start once, and the following done then completes the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 1 | Configure command pulse |
| issue_i | input | 1 | Issue command pulse |
| pause_i | input | 1 | Pause command pulse |
| resume_i | input | 1 | Resume command pulse |
| term_i | input | 1 | Terminate command pulse |
| chunk_cnt_i | input | CNT_W | Number of queued chunks, sampled on issue |
| done_i | input | 1 | Engine chunk-done event |
| abort_i | input | 1 | Engine abort event |
| eng_idle_i | input | 1 | Engine reports no work in flight |
| ack_o | output | 1 | Command accepted pulse |
| nak_o | output | 1 | Command rejected pulse |
| start_o | output | 1 | Start-next-chunk pulse |
| complete_o | output | 1 | Work complete pulse |
| status_o | output | 2 | Channel status |
| request_o | output | 2 | Pending request |
| configured_o | output | 1 | Configured flag |

## Verification
The bench sweeps chunk counts from one to four and counts start pulses against the expected total. A counter that is off by one launches a chunk too many or too few, or completes early. Pause and stop are driven while busy and then released by a done event. A design that acted on them at once would change status before the done arrives.

Further scenarios cover a command coinciding with a done event, abort together with done, two commands in the same cycle, and terminate in each status. They also cover the case where the engine already reports idle. A design with the wrong priority would accept the command, take the done path, or clear the configured flag in the wrong case. Resuming after the last chunk checks saturation: an underflowing count would emit an extra start instead of completing.

// File: rtl/dcc_pkg.sv
// Package: shared encodings for the DMA channel controller.
// Assumes: status and request share a 2-bit field; encodings are visible at ports.
package dcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PAUSE = 2'd1,
        ST_BUSY  = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        RQ_NONE  = 2'd0,
        RQ_STOP  = 2'd1,
        RQ_PAUSE = 2'd2
    } req_e;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_CFG    = 3'd1,
        CMD_ISSUE  = 3'd2,
        CMD_PAUSE  = 3'd3,
        CMD_RESUME = 3'd4,
        CMD_TERM   = 3'd5
    } cmd_e;

    localparam int NUM_CMDS = 5;

endpackage

// File: rtl/dcc_cmd_select.sv
// Module: picks one command from the simultaneous command pulses.
// Order of service: terminate, pause, resume, issue, configure.
// Assumes: the pulses are synchronous to clk; purely combinational.
module dcc_cmd_select
    import dcc_pkg::*;
(
    input  logic [NUM_CMDS-1:0] cmd_vec_i,  // {term, pause, resume, issue, cfg}
    output cmd_e                sel_o,
    output logic                any_o
);

    localparam cmd_e SVC_ORDER [NUM_CMDS] = '{CMD_CFG, CMD_ISSUE, CMD_RESUME, CMD_PAUSE, CMD_TERM};

    // Highest bit index wins: scan upward so the last match overrides.
    always_comb begin
        sel_o = CMD_NONE;
        for (int k = 0; k < NUM_CMDS; k++) begin
            if (cmd_vec_i[k]) sel_o = SVC_ORDER[k];
        end
    end

    // Any command present at all.
    assign any_o = |cmd_vec_i;

endmodule

// File: rtl/dcc_chunk_ctr.sv
// Module: remaining-chunk counter.
// Loads count-1 on issue (the issue itself launches one chunk) and
// decrements on each later launch, saturating at zero.
// Assumes: load and dec are never high together.
module dcc_chunk_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             remain_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Counter register: load, saturating decrement, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (load_val_i == '0) ? '0 : load_val_i - ONE;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Chunks still waiting to be launched.
    assign remain_o = (cnt_q != '0);

    // Decrement at zero must leave the count at zero.
    p_no_underflow_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && cnt_q == '0) |=> (cnt_q == '0));

    // A plain decrement lowers the count by exactly one.
    p_dec_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/dcc_ctrl_core.sv
// Module: channel state machine and registered response/pulse outputs.
// Events from the engine are applied first; a command that coincides with
// any event is rejected. All outputs are registered.
// Assumes: sel_i/any_i come from dcc_cmd_select; remain_i from the counter.
module dcc_ctrl_core
    import dcc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             sel_i,
    input  logic             any_i,
    input  logic [CNT_W-1:0] chunk_cnt_i,
    input  logic             done_i,
    input  logic             abort_i,
    input  logic             eng_idle_i,
    input  logic             remain_i,
    output logic             ctr_load_o,
    output logic             ctr_dec_o,
    output logic             ack_o,
    output logic             nak_o,
    output logic             start_o,
    output logic             complete_o,
    output status_e          status_o,
    output req_e             request_o,
    output logic             configured_o
);

    status_e st_q, st_n;
    req_e    rq_q, rq_n;
    logic    cfg_q, cfg_n;
    logic    ack_n, nak_n, start_n, cmpl_n;
    logic    busy, evt_seen;

    assign busy     = (st_q == ST_BUSY);
    assign evt_seen = done_i | abort_i;

    // Next-state and pulse decisions: events first, then the chosen command.
    always_comb begin
        st_n       = st_q;
        rq_n       = rq_q;
        cfg_n      = cfg_q;
        ack_n      = 1'b0;
        nak_n      = 1'b0;
        start_n    = 1'b0;
        cmpl_n     = 1'b0;
        ctr_load_o = 1'b0;
        ctr_dec_o  = 1'b0;

        if (busy && abort_i) begin
            cmpl_n = 1'b1;
            rq_n   = RQ_NONE;
            st_n   = ST_IDLE;
        end else if (busy && done_i) begin
            case (rq_q)
                RQ_NONE: begin
                    if (remain_i) begin
                        start_n   = 1'b1;
                        ctr_dec_o = 1'b1;
                    end else begin
                        cmpl_n = 1'b1;
                        st_n   = ST_IDLE;
                    end
                end
                RQ_STOP: begin
                    cmpl_n = 1'b1;
                    rq_n   = RQ_NONE;
                    st_n   = ST_IDLE;
                end
                RQ_PAUSE: begin
                    rq_n = RQ_NONE;
                    st_n = ST_PAUSE;
                end
                default: ;
            endcase
        end

        if (any_i && evt_seen) begin
            nak_n = 1'b1;
        end else if (any_i) begin
            case (sel_i)
                CMD_CFG: begin
                    cfg_n = 1'b1;
                    ack_n = 1'b1;
                end
                CMD_ISSUE: begin
                    if (cfg_q && rq_q == RQ_NONE && st_q == ST_IDLE && chunk_cnt_i != '0) begin
                        st_n       = ST_BUSY;
                        start_n    = 1'b1;
                        ctr_load_o = 1'b1;
                        ack_n      = 1'b1;
                    end else begin
                        nak_n = 1'b1;
                    end
                end
                CMD_PAUSE: begin
                    if (cfg_q && busy && rq_q == RQ_NONE) begin
                        rq_n  = RQ_PAUSE;
                        ack_n = 1'b1;
                    end else begin
                        nak_n = 1'b1;
                    end
                end
                CMD_RESUME: begin
                    if (cfg_q && st_q == ST_PAUSE && rq_q == RQ_NONE) begin
                        st_n      = ST_BUSY;
                        start_n   = 1'b1;
                        ctr_dec_o = 1'b1;
                        ack_n     = 1'b1;
                    end else begin
                        nak_n = 1'b1;
                    end
                end
                CMD_TERM: begin
                    if (!cfg_q) begin
                        ack_n = 1'b1;
                    end else if (st_q == ST_PAUSE || st_q == ST_IDLE) begin
                        st_n  = ST_IDLE;
                        cfg_n = 1'b0;
                        ack_n = 1'b1;
                    end else if (eng_idle_i) begin
                        st_n  = ST_IDLE;
                        rq_n  = RQ_NONE;
                        cfg_n = 1'b0;
                        ack_n = 1'b1;
                    end else if (rq_q == RQ_STOP) begin
                        nak_n = 1'b1;
                    end else begin
                        rq_n  = RQ_STOP;
                        ack_n = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            rq_q       <= RQ_NONE;
            cfg_q      <= 1'b0;
            ack_o      <= 1'b0;
            nak_o      <= 1'b0;
            start_o    <= 1'b0;
            complete_o <= 1'b0;
        end else begin
            st_q       <= st_n;
            rq_q       <= rq_n;
            cfg_q      <= cfg_n;
            ack_o      <= ack_n;
            nak_o      <= nak_n;
            start_o    <= start_n;
            complete_o <= cmpl_n;
        end
    end

    assign status_o     = st_q;
    assign request_o    = rq_q;
    assign configured_o = cfg_q;

    // Accept and reject never together.
    p_resp_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && nak_o));

    // A served command always yields a response on the next cycle.
    p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_i |=> (ack_o || nak_o));

    // Status never takes the unused code.
    p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 2'd3);

    // A launched chunk always leaves the channel busy.
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (st_q == ST_BUSY));

    // Completion always leaves the channel idle.
    p_cmpl_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o |-> (st_q == ST_IDLE));

    // A pending request exists only while busy.
    p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_q != RQ_NONE) |-> (st_q == ST_BUSY));

    // Configured flag drops only after a terminate was selected.
    p_cfg_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q) |-> $past(sel_i == CMD_TERM));

    // An event on the same cycle as a command forces a reject.
    p_evt_prio_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (any_i && (done_i || abort_i)) |=> nak_o);

endmodule

// File: rtl/dma_chan_ctrl.sv
// Module: top of the DMA channel pause/stop controller.
// Wires the command selector, the chunk counter and the state core.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module dma_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_i,
    input  logic             issue_i,
    input  logic             pause_i,
    input  logic             resume_i,
    input  logic             term_i,
    input  logic [CNT_W-1:0] chunk_cnt_i,
    input  logic             done_i,
    input  logic             abort_i,
    input  logic             eng_idle_i,
    output logic             ack_o,
    output logic             nak_o,
    output logic             start_o,
    output logic             complete_o,
    output logic [1:0]       status_o,
    output logic [1:0]       request_o,
    output logic             configured_o
);

    cmd_e    sel;
    logic    cmd_any;
    logic    ctr_load, ctr_dec, remain;
    status_e st_w;
    req_e    rq_w;

    dcc_cmd_select u_sel (
        .cmd_vec_i ({term_i, pause_i, resume_i, issue_i, cfg_i}),
        .sel_o     (sel),
        .any_o     (cmd_any)
    );

    dcc_chunk_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (chunk_cnt_i),
        .dec_i      (ctr_dec),
        .remain_o   (remain)
    );

    dcc_ctrl_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sel),
        .any_i        (cmd_any),
        .chunk_cnt_i  (chunk_cnt_i),
        .done_i       (done_i),
        .abort_i      (abort_i),
        .eng_idle_i   (eng_idle_i),
        .remain_i     (remain),
        .ctr_load_o   (ctr_load),
        .ctr_dec_o    (ctr_dec),
        .ack_o        (ack_o),
        .nak_o        (nak_o),
        .start_o      (start_o),
        .complete_o   (complete_o),
        .status_o     (st_w),
        .request_o    (rq_w),
        .configured_o (configured_o)
    );

    assign status_o  = st_w;
    assign request_o = rq_w;

endmodule

// File: tb/dma_chan_ctrl_test.sv
// Bench: scripted sweeps over chunk counts and command/event orderings.
// Expected values are written from the requirements as
// {ack, nak, start, complete, status[1:0], request[1:0], configured}.
module dma_chan_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_i = 0, issue_i = 0, pause_i = 0, resume_i = 0, term_i = 0;
    logic [CNT_W-1:0] chunk_cnt_i = '0;
    logic done_i = 0, abort_i = 0, eng_idle_i = 0;
    logic ack_o, nak_o, start_o, complete_o, configured_o;
    logic [1:0] status_o, request_o;

    int errors = 0;
    int checks = 0;
    int starts = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctrl #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_i(cfg_i), .issue_i(issue_i), .pause_i(pause_i),
        .resume_i(resume_i), .term_i(term_i), .chunk_cnt_i(chunk_cnt_i),
        .done_i(done_i), .abort_i(abort_i), .eng_idle_i(eng_idle_i),
        .ack_o(ack_o), .nak_o(nak_o), .start_o(start_o),
        .complete_o(complete_o), .status_o(status_o),
        .request_o(request_o), .configured_o(configured_o)
    );

    // Drive one cycle of inputs from a negedge, sample at the next negedge.
    task automatic tick(input logic c, input logic is, input logic p, input logic r,
                        input logic t, input logic d, input logic a, input logic e,
                        input int n);
        cfg_i = c; issue_i = is; pause_i = p; resume_i = r; term_i = t;
        done_i = d; abort_i = a; eng_idle_i = e; chunk_cnt_i = CNT_W'(n);
        @(posedge clk);
        @(negedge clk);
        cfg_i = 0; issue_i = 0; pause_i = 0; resume_i = 0; term_i = 0;
        done_i = 0; abort_i = 0; eng_idle_i = 0;
    endtask

    task automatic chk(input string tag, input logic [8:0] exp);
        logic [8:0] act;
        act = {ack_o, nak_o, start_o, complete_o, status_o, request_o, configured_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 / R2: reset state, idle/none/unconfigured
        chk("R1 reset", 9'b0000_00_00_0);

        // R5: issue while unconfigured is rejected
        tick(0,1,0,0,0,0,0,0,3); chk("R5 issue unconfigured", 9'b0100_00_00_0);
        // R7: resume while unconfigured is rejected
        tick(0,0,0,1,0,0,0,0,0); chk("R7 resume unconfigured", 9'b0100_00_00_0);
        // R4: configure accepted
        tick(1,0,0,0,0,0,0,0,0); chk("R4 configure", 9'b1000_00_00_1);
        // R5: zero chunks rejected
        tick(0,1,0,0,0,0,0,0,0); chk("R5 zero chunks", 9'b0100_00_00_1);
        // R13: done while idle ignored
        tick(0,0,0,0,0,1,0,0,0); chk("R13 done idle", 9'b0000_00_00_1);
        // R6: pause while idle rejected
        tick(0,0,1,0,0,0,0,0,0); chk("R6 pause idle", 9'b0100_00_00_1);

        // R8 / R5: sweep chunk counts, count launches
        for (int n = 1; n <= 4; n++) begin
            starts = 0;
            tick(0,1,0,0,0,0,0,0,n); chk("R5 issue", 9'b1010_10_00_1);
            if (start_o) starts++;
            for (int k = 1; k < n; k++) begin
                tick(0,0,0,0,0,1,0,0,0); chk("R8 next chunk", 9'b0010_10_00_1);
                if (start_o) starts++;
            end
            tick(0,0,0,0,0,1,0,0,0); chk("R8 last done", 9'b0001_00_00_1);
            chk_int("R8 launch count", starts, n);
        end

        // R6 / R9 / R7: pause takes effect at done
        tick(0,1,0,0,0,0,0,0,3); chk("R5 issue 3", 9'b1010_10_00_1);
        tick(0,0,1,0,0,0,0,0,0); chk("R6 pause busy", 9'b1000_10_10_1);
        tick(0,0,1,0,0,0,0,0,0); chk("R6 pause pending", 9'b0100_10_10_1);
        tick(0,0,0,1,0,0,0,0,0); chk("R7 resume pending", 9'b0100_10_10_1);
        tick(0,0,0,0,0,1,0,0,0); chk("R9 done pause", 9'b0000_01_00_1);
        tick(0,0,0,1,0,0,0,0,0); chk("R7 resume", 9'b1010_10_00_1);
        tick(0,0,0,1,0,0,0,0,0); chk("R7 resume busy", 9'b0100_10_00_1);
        tick(0,0,0,0,0,1,0,0,0); chk("R8 after resume", 9'b0010_10_00_1);
        tick(0,0,0,0,0,1,0,0,0); chk("R8 finish", 9'b0001_00_00_1);

        // R12 / R9: stop request
        tick(0,1,0,0,0,0,0,0,3); chk("R5 issue stop", 9'b1010_10_00_1);
        tick(0,0,0,0,1,0,0,0,0); chk("R12 term stop", 9'b1000_10_01_1);
        tick(0,0,0,0,1,0,0,0,0); chk("R12 term twice", 9'b0100_10_01_1);
        tick(0,0,0,0,0,1,0,0,0); chk("R9 done stop", 9'b0001_00_00_1);

        // R10: abort
        tick(0,1,0,0,0,0,0,0,2); chk("R5 issue abort", 9'b1010_10_00_1);
        tick(0,0,0,0,0,0,1,0,0); chk("R10 abort", 9'b0001_00_00_1);
        tick(0,0,0,0,0,0,1,0,0); chk("R13 abort idle", 9'b0000_00_00_1);

        // R12: terminate with engine already idle
        tick(0,1,0,0,0,0,0,0,2); chk("R5 issue eng", 9'b1010_10_00_1);
        tick(0,0,1,0,0,0,0,0,0); chk("R6 pause eng", 9'b1000_10_10_1);
        tick(0,0,0,0,1,0,0,1,0); chk("R12 term eng idle", 9'b1000_00_00_0);

        // R11: terminate unconfigured, idle, paused
        tick(0,0,0,0,1,0,0,0,0); chk("R11 term unconfigured", 9'b1000_00_00_0);
        tick(1,0,0,0,0,0,0,0,0); chk("R4 reconfigure", 9'b1000_00_00_1);
        tick(0,0,0,0,1,0,0,0,0); chk("R11 term idle", 9'b1000_00_00_0);
        tick(1,0,0,0,0,0,0,0,0); chk("R4 reconfigure", 9'b1000_00_00_1);
        tick(0,1,0,0,0,0,0,0,2); chk("R5 issue", 9'b1010_10_00_1);
        tick(0,0,1,0,0,0,0,0,0); chk("R6 pause", 9'b1000_10_10_1);
        tick(0,0,0,0,0,1,0,0,0); chk("R9 paused", 9'b0000_01_00_1);
        tick(0,0,0,0,1,0,0,0,0); chk("R11 term paused", 9'b1000_00_00_0);

        // R3: simultaneous commands, issue beats configure
        tick(1,1,0,0,0,0,0,0,2); chk("R3 issue over cfg", 9'b0100_00_00_0);
        tick(1,0,0,0,0,0,0,0,0); chk("R4 configure", 9'b1000_00_00_1);
        tick(0,1,0,0,0,0,0,0,3); chk("R5 issue", 9'b1010_10_00_1);
        // R3: pause beats resume
        tick(0,0,1,1,0,0,0,0,0); chk("R3 pause over resume", 9'b1000_10_10_1);
        // R13: command with done is rejected, done still acts (pause -> paused)
        tick(0,0,0,1,0,1,0,0,0); chk("R13 cmd with done", 9'b0100_01_00_1);
        tick(0,0,0,1,0,0,0,0,0); chk("R7 resume", 9'b1010_10_00_1);
        // R10: abort beats done (one chunk still remains)
        tick(0,0,0,0,0,1,1,0,0); chk("R10 abort over done", 9'b0001_00_00_1);

        // R14: resume after last launch saturates the count
        tick(0,1,0,0,0,0,0,0,1); chk("R14 issue 1", 9'b1010_10_00_1);
        tick(0,0,1,0,0,0,0,0,0); chk("R14 pause", 9'b1000_10_10_1);
        tick(0,0,0,0,0,1,0,0,0); chk("R14 paused", 9'b0000_01_00_1);
        tick(0,0,0,1,0,0,0,0,0); chk("R14 resume", 9'b1010_10_00_1);
        tick(0,0,0,0,0,1,0,0,0); chk("R14 complete", 9'b0001_00_00_1);

        // R1: reset clears everything again
        rst_n = 1'b0;
        tick(0,0,0,0,0,0,0,0,0);
        rst_n = 1'b1;
        chk("R1 reset again", 9'b0000_00_00_0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule